// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous fast-page-mode DRAM array of 1M words by 144 bits. It turns each host read or write into a row-strobe, column-strobe, write-enable and multiplexed-address sequence. Every timing limit is a parameter in nanoseconds and is converted to controller clock cycles by rounding up. The only exception is the longest row-strobe low time, which is rounded down so that the limit is never exceeded.

After a row has been opened, it stays open. Later host requests to the same row are served with column cycles only. A request to another row closes the page, waits out precharge and the row cycle time, and then opens the new row. Writes always use the early form: write enable falls before the column strobe, so the array never drives the data pins during a write. A refresh request closes any open page. It is granted only while the array is idle with the row strobe high, and during that time the controller drives no strobe and accepts no host request.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, ras_n is high, cas_n is 2'b11, we_n is high, dq_oe is low, rvalid is low and refresh_gnt is low. ready is high whenever refresh_req is low.
- R2: The host address splits into row = addr[19:10] and column = addr[9:0]. ma carries the row when ras_n falls and the column when cas_n falls.
- R3: A read returns the array word in rdata, marked by a one-cycle rvalid pulse. Results arrive in request order. dq_in is sampled no earlier than T_RAC after ras_n falls, T_CAC after cas_n falls, and T_AA after the column address appears on ma.
- R4: For a write, we_n is already low and dq_oe is high when cas_n falls, and dq_out carries the host data. For a read, we_n is high when cas_n falls.
- R5: While the page is open, a request to the open row causes no new ras_n fall.
- R6: A request to another row raises ras_n first. ras_n then stays high for at least T_RP, and two ras_n falls are at least T_RC apart.
- R7: Within one open page, two cas_n falls are at least T_PC apart.
- R8: ras_n never stays low longer than T_RAS_MAX. An idle open page is closed before that limit.
- R9: A pending refresh_req closes an open page and drops ready. refresh_gnt is high only while ras_n and cas_n are high and the controller is idle. While the grant is held, host requests are ignored and no strobe falls.
- R10: Both column strobe bits always move together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| we | input | 1 | Host request is a write |
| addr | input | 20 | Word address: row in the upper half, column in the lower half |
| wdata | input | 144 | Write data |
| ready | output | 1 | Request taken when req and ready are both high at a clock edge |
| rdata | output | 144 | Read data |
| rvalid | output | 1 | One-cycle pulse marking rdata |
| refresh_req | input | 1 | Refresh wanted |
| refresh_gnt | output | 1 | Array idle and handed over for refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes for the two word halves, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | 10 | Multiplexed row/column address |
| dq_out | output | 144 | Data toward the array |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 144 | Data from the array |

## Verification
The bench drives a timing-aware array model. The model returns the inverted word whenever it is sampled before any of the three read-access limits has passed, so an early sample shows up as a data mismatch. Runs of same-row requests separate page hits from reopening: the count of row-strobe falls must stay at one. A switch to another row tests the precharge and row-cycle spacing. Random mixes of reads and writes over a few rows, with idle gaps, check data ordering and the early-write pin sequence. Directed cases cover a refresh arriving while a page is open and a page left idle past the row-strobe limit.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int CLK_NS       = 10,
  parameter int A_W          = 10,
  parameter int DATA_W       = 144,
  parameter int T_RC_NS      = 110,
  parameter int T_PC_NS      = 40,
  parameter int T_RAC_NS     = 65,
  parameter int T_CAC_NS     = 20,
  parameter int T_AA_NS      = 35,
  parameter int T_RP_NS      = 40,
  parameter int T_RCD_NS     = 20,
  parameter int T_RAS_MAX_NS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [2*A_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              refresh_req,
  output logic              refresh_gnt,
  output logic              ras_n,
  output logic [1:0]        cas_n,
  output logic              we_n,
  output logic [A_W-1:0]    ma,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_RC   = cyc(T_RC_NS);
  localparam int N_PC   = cyc(T_PC_NS);
  localparam int N_RAC  = cyc(T_RAC_NS);
  localparam int N_RP   = cyc(T_RP_NS);
  localparam int N_RCD  = cyc(T_RCD_NS);
  localparam int N_CAS0 = (cyc(T_CAC_NS) > cyc(T_AA_NS) - 1) ? cyc(T_CAC_NS) : cyc(T_AA_NS) - 1;
  localparam int N_CAS  = (N_CAS0 < 1) ? 1 : N_CAS0;
  localparam int N_RAS  = T_RAS_MAX_NS / CLK_NS;
  localparam int N_OPEN = N_RAS - N_PC - N_CAS - 3;
  localparam int RW     = $clog2(N_RAS + N_RC + 1) + 1;
  localparam int PW     = $clog2(N_PC + 1) + 1;
  localparam int MX0    = (N_RCD > N_RP) ? N_RCD : N_RP;
  localparam int MX     = (MX0 > N_CAS) ? MX0 : N_CAS;
  localparam int CW     = $clog2(MX + 1) + 1;

  localparam logic [RW-1:0] L_RC   = RW'(N_RC);
  localparam logic [RW-1:0] L_RAC  = RW'(N_RAC);
  localparam logic [RW-1:0] L_OPEN = RW'(N_OPEN);
  localparam logic [RW-1:0] L_RAS  = RW'(N_RAS);
  localparam logic [PW-1:0] L_PC   = PW'(N_PC);
  localparam logic [CW-1:0] L_RCD  = CW'(N_RCD);
  localparam logic [CW-1:0] L_CAS  = CW'(N_CAS);
  localparam logic [CW-1:0] L_RP   = CW'(N_RP);

  typedef enum logic [2:0] {IDLE, ROWA, RCD, COLA, CAS, OPEN, PRE} st_t;
  st_t st;

  logic [CW-1:0]  cnt;
  logic [RW-1:0]  rcnt;
  logic [PW-1:0]  pcnt;
  logic [A_W-1:0] open_row, cur_col;
  logic           cur_wr, cas_q, close_now, take;

  wire [A_W-1:0] row_in = addr[2*A_W-1:A_W];
  wire [A_W-1:0] col_in = addr[A_W-1:0];

  assign close_now   = refresh_req || (rcnt >= L_OPEN) || (req && row_in != open_row);
  assign ready       = (st == IDLE && !refresh_req) || (st == OPEN && !close_now);
  assign take        = req && ready;
  assign refresh_gnt = refresh_req && st == IDLE;
  assign cas_n       = {2{cas_q}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ras_n <= 1'b1; cas_q <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
      ma <= '0; dq_out <= '0; rdata <= '0; rvalid <= 1'b0;
      cnt <= '0; rcnt <= '1; pcnt <= '1;
      open_row <= '0; cur_col <= '0; cur_wr <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      if (cnt  != '1) cnt  <= cnt + 1'b1;
      if (rcnt != '1) rcnt <= rcnt + 1'b1;
      if (pcnt != '1) pcnt <= pcnt + 1'b1;
      case (st)
        IDLE: if (take) begin
          open_row <= row_in; cur_col <= col_in; cur_wr <= we; dq_out <= wdata;
          ma <= row_in; st <= ROWA; cnt <= 1;
        end
        ROWA: begin
          ras_n <= 1'b0; rcnt <= 1; st <= RCD; cnt <= 1;
        end
        RCD: if (cnt >= L_RCD) begin
          ma <= cur_col; we_n <= ~cur_wr; dq_oe <= cur_wr; st <= COLA; cnt <= 1;
        end
        COLA: if (pcnt >= L_PC) begin
          cas_q <= 1'b0; pcnt <= 1; st <= CAS; cnt <= 1;
        end
        CAS: if (cnt >= L_CAS && (cur_wr || rcnt >= L_RAC)) begin
          cas_q <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
          if (!cur_wr) begin
            rdata <= dq_in; rvalid <= 1'b1;
          end
          st <= OPEN; cnt <= 1;
        end
        OPEN: if (close_now) begin
          ras_n <= 1'b1; st <= PRE; cnt <= 1;
        end else if (take) begin
          cur_col <= col_in; cur_wr <= we; dq_out <= wdata;
          ma <= col_in; we_n <= ~we; dq_oe <= we; st <= COLA; cnt <= 1;
        end
        PRE: if (cnt >= L_RP && rcnt >= L_RC) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  a_r9_gnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_gnt |-> (ras_n && cas_n == 2'b11 && !ready));
  a_r3_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r4_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> $stable(we_n));
  a_r4_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n[0] && !we_n) |-> dq_oe);
  a_r8_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> rcnt <= L_RAS);
  a_r10_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> $fell(cas_n[1]));
endmodule

// File: tb/sim_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_dram_ctrl;
  localparam int DW = 144;
  localparam longint T_RC = 110, T_PC = 40, T_RAC = 65, T_CAC = 20, T_AA = 35, T_RP = 40;
  localparam longint T_RASMAX = 800;

  logic clk = 0, rst_n = 0, req = 0, we = 0, refresh_req = 0;
  logic [19:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, dq_out, dq_in = '0;
  logic ready, rvalid, refresh_gnt, ras_n, we_n, dq_oe;
  logic [1:0] cas_n;
  logic [9:0] ma;

  fpm_dram_ctrl #(.T_RAS_MAX_NS(800)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .refresh_req(refresh_req),
    .refresh_gnt(refresh_gnt), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, ras_falls = 0;
  logic [DW-1:0] mem [logic [19:0]];
  logic [DW-1:0] shadow [logic [19:0]];
  logic [DW-1:0] expq [$];
  logic [19:0] acc_addr = '0;
  logic [9:0] row_lat = '0;
  longint ras_t = -100000, ras_up_t = -100000, cas_t = -100000, ma_t = -100000, we_t = -100000;
  logic took_q = 0;

  function automatic logic [DW-1:0] pat(input logic [19:0] a);
    return {a[3:0], {7{a ^ 20'h5A3C1}}};
  endfunction

  function automatic logic [DW-1:0] mem_rd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  function automatic logic [DW-1:0] sh_rd(input logic [19:0] a);
    return shadow.exists(a) ? shadow[a] : pat(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) took_q <= req && ready;
  always @(ma) ma_t = $time;
  always @(we_n) we_t = $time;

  always @(negedge ras_n) if (rst_n) begin
    chk($time - ras_t >= T_RC, "R6 ras fall spacing", DW'($time - ras_t), DW'(T_RC));
    chk($time - ras_up_t >= T_RP, "R6 precharge", DW'($time - ras_up_t), DW'(T_RP));
    chk(ma == acc_addr[19:10], "R2 row on ma", DW'(ma), DW'(acc_addr[19:10]));
    ras_t = $time; row_lat = ma; ras_falls++;
  end

  always @(posedge ras_n) if (rst_n) begin
    chk($time - ras_t <= T_RASMAX, "R8 ras low width", DW'($time - ras_t), DW'(T_RASMAX));
    ras_up_t = $time;
  end

  always @(negedge cas_n[0]) if (rst_n) begin
    chk(cas_n[1] == 1'b0, "R10 cas pair", DW'(cas_n), 0);
    if (cas_t > ras_t)
      chk($time - cas_t >= T_PC, "R7 page cycle", DW'($time - cas_t), DW'(T_PC));
    chk(ma == acc_addr[9:0], "R2 column on ma", DW'(ma), DW'(acc_addr[9:0]));
    if (!we_n) begin
      chk(dq_oe && we_t < $time, "R4 early write setup", DW'({dq_oe, 1'b0}), 2);
      mem[{row_lat, ma}] = dq_out;
    end
    cas_t = $time;
  end

  always @(negedge clk) begin
    longint tn;
    logic [DW-1:0] d;
    tn = $time + 5;
    d = mem_rd({row_lat, ma});
    if (!ras_n && !cas_n[0] && we_n && tn - ras_t >= T_RAC && tn - cas_t >= T_CAC && tn - ma_t >= T_AA)
      dq_in <= d;
    else
      dq_in <= ~d;
    if (rst_n && rvalid) begin
      if (expq.size() == 0) chk(0, "R3 unexpected rvalid", rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(rdata == e, "R3 read data", rdata, e);
      end
    end
  end

  task automatic book(input bit wr, input logic [19:0] a, input logic [DW-1:0] d);
    acc_addr = a;
    if (wr) shadow[a] = d;
    else expq.push_back(sh_rd(a));
  endtask

  task automatic access(input bit wr, input logic [19:0] a, input logic [DW-1:0] d);
    req = 1; we = wr; addr = a; wdata = d;
    do @(negedge clk); while (!took_q);
    book(wr, a, d);
    req = 0;
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    chk(expq.size() == 0, "R3 all reads returned", DW'(expq.size()), 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && we_n && !dq_oe && !rvalid && !refresh_gnt && ready,
        "R1 reset state", DW'({ras_n, cas_n, we_n, dq_oe, rvalid, refresh_gnt, ready}), DW'(8'b1111_0001));

    f0 = ras_falls;
    access(1, {10'd5, 10'd1}, {9{16'hA5A5}});
    access(0, {10'd5, 10'd1}, '0);
    access(0, {10'd5, 10'd2}, '0);
    access(1, {10'd5, 10'd3}, {9{16'h1234}});
    access(0, {10'd5, 10'd3}, '0);
    drain();
    chk(ras_falls - f0 == 1, "R5 page hits keep row open", DW'(ras_falls - f0), 1);

    f0 = ras_falls;
    access(0, {10'd6, 10'd7}, '0);
    access(0, {10'd5, 10'd1}, '0);
    drain();
    chk(ras_falls - f0 == 2, "R6 row miss reopens", DW'(ras_falls - f0), 2);

    access(0, {10'd9, 10'd4}, '0);
    drain();
    refresh_req = 1;
    for (int i = 0; i < 50 && !refresh_gnt; i++) @(negedge clk);
    chk(refresh_gnt && ras_n && cas_n == 2'b11, "R9 grant with array idle",
        DW'({refresh_gnt, ras_n, cas_n}), 4'b1111);
    chk(!ready, "R9 ready low under refresh", DW'(ready), 0);
    f0 = ras_falls;
    req = 1; we = 0; addr = {10'd9, 10'd4};
    repeat (6) @(negedge clk);
    chk(ras_falls == f0 && !took_q && ras_n, "R9 request ignored while granted",
        DW'(ras_falls - f0), 0);
    refresh_req = 0;
    do @(negedge clk); while (!took_q);
    book(0, {10'd9, 10'd4}, '0);
    req = 0;
    drain();

    access(0, {10'd3, 10'd8}, '0);
    repeat (110) @(negedge clk);
    chk(ras_n == 1'b1, "R8 idle page closed", DW'(ras_n), 1);
    drain();

    for (int n = 0; n < 400; n++) begin
      logic [19:0] a;
      logic [DW-1:0] d;
      bit wr;
      a = {8'd0, 2'($urandom % 4), 7'd0, 3'($urandom % 8)};
      wr = ($urandom % 2) == 1;
      d = {$urandom, $urandom, $urandom, $urandom, 16'($urandom)};
      access(wr, a, d);
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule